// File: doc/BRIEF.md
# Segment Address Translator

This block maps a 32-bit virtual address to a 32-bit physical address by segmentation. The upper byte of the virtual address chooses one of 256 segment descriptors. The remaining 24 bits are a byte offset into that segment. Each descriptor is held in an on-chip register table and carries three fields: a presence flag, a 32-bit base address and a byte length. The block adds the base to the offset and compares the offset against the length. If the descriptor is absent or the offset falls outside the segment, the access is flagged as a fault.

Software or a control block fills the table through a single-entry write port. Lookups arrive as one-cycle requests. Each request produces one registered response on the following cycle. The response carries a valid strobe, the physical address and a fault flag.

Program, data and stack regions of a task are held as separate descriptors, each with its own base and length. The caller selects a region by the segment number it places in the address.

Top module: `seg_translator`

## Requirements
- R1: After synchronous reset, rsp_valid, rsp_paddr and rsp_fault are all 0, and every descriptor is absent.
- R2: req_vaddr bits 31:24 select the descriptor, and bits 23:0 are the zero-extended byte offset.
- R3: For a request in cycle N, rsp_valid is 1 in cycle N+1. For an in-range access, rsp_paddr equals the descriptor base plus the offset, modulo 2^32, and rsp_fault is 0.
- R4: The access faults when the offset is greater than or equal to the 25-bit byte length. A length of 0 always faults. A length of 2^24 never faults on a present descriptor.
- R5: A lookup of an absent descriptor faults, whatever its base and length.
- R6: When rsp_fault is 1, rsp_paddr is 0.
- R7: In a cycle after one with no request, rsp_valid is 0, and rsp_paddr and rsp_fault keep their previous values.
- R8: tbl_we writes tbl_live, tbl_base and tbl_span into descriptor tbl_sel. A lookup issued in the same cycle sees the old contents, including when it targets the same descriptor. Lookups in later cycles see the new contents.
- R9: Writing tbl_live = 0 makes a descriptor absent, so later lookups of it fault.
- R10: A sum of base and offset that exceeds 32 bits wraps, keeping only the low 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Descriptor write strobe |
| tbl_sel | input | 8 | Descriptor index to write |
| tbl_live | input | 1 | Presence flag to store |
| tbl_base | input | 32 | Segment base to store |
| tbl_span | input | 25 | Segment length in bytes to store |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address of the lookup |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 1 | Absent descriptor or offset out of range |

## Verification
On every cycle, the assertions check the following:
- the one-cycle request-to-response timing;
- that responses hold when no request arrives;
- that a faulting response carries a zero address;
- that a table write lands in the addressed descriptor;
- that a non-faulting result came from a present descriptor with an offset inside its length.

Other behaviours need the bench's scenarios and its reference model:
- the exact sum of base and offset;
- the boundary at offset equal to length;
- the zero-length and full-length cases;
- address wrap-around;
- the old-contents rule for a write and a lookup to the same descriptor in one cycle.

// File: rtl/segx_pkg.sv
package segx_pkg;

    parameter int VA_W  = 32;
    parameter int SEG_W = 8;
    parameter int OFF_W = VA_W - SEG_W;
    parameter int PA_W  = 32;
    parameter int LEN_W = OFF_W + 1;
    parameter int N_SEG = 1 << SEG_W;

    typedef struct packed {
        logic             live;
        logic [PA_W-1:0]  base;
        logic [LEN_W-1:0] span;
    } seg_desc_t;

    typedef struct packed {
        logic [SEG_W-1:0] sel;
        logic [OFF_W-1:0] off;
    } vaddr_t;

    typedef enum logic [1:0] {
        XL_OK     = 2'd0,
        XL_ABSENT = 2'd1,
        XL_LIMIT  = 2'd2
    } verdict_e;

    typedef struct packed {
        logic            valid;
        logic            fault;
        logic [PA_W-1:0] paddr;
    } seg_rsp_t;

    function automatic logic off_outside(input logic [OFF_W-1:0] off,
                                         input logic [LEN_W-1:0] span);
        return {1'b0, off} >= span;
    endfunction

    function automatic logic [PA_W-1:0] form_paddr(input logic [PA_W-1:0]  base,
                                                   input logic [OFF_W-1:0] off);
        return base + PA_W'(off);
    endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
    import segx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  seg_desc_t        wr_desc,
    input  logic [SEG_W-1:0] rd_idx,
    output seg_desc_t        rd_desc
);

    seg_desc_t slots [N_SEG];

    for (genvar g = 0; g < N_SEG; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g] <= '0;
            end else if (wr_en && (wr_idx == SEG_W'(g))) begin
                slots[g] <= wr_desc;
            end
        end
    end

    // Read sees contents before any write of this cycle.
    assign rd_desc = slots[rd_idx];

    p_write_lands_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (slots[$past(wr_idx)] == $past(wr_desc)))
        else $error("table write did not land");

endmodule

// File: rtl/seg_check.sv
module seg_check
    import segx_pkg::*;
(
    input  seg_desc_t        desc,
    input  logic [OFF_W-1:0] off,
    output verdict_e         verdict,
    output logic [PA_W-1:0]  paddr
);

    always_comb begin
        if (!desc.live) begin
            verdict = XL_ABSENT;
        end else if (off_outside(off, desc.span)) begin
            verdict = XL_LIMIT;
        end else begin
            verdict = XL_OK;
        end
        paddr = (verdict == XL_OK) ? form_paddr(desc.base, off) : '0;
    end

endmodule

// File: rtl/seg_translator.sv
module seg_translator
    import segx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tbl_we,
    input  logic [SEG_W-1:0]  tbl_sel,
    input  logic              tbl_live,
    input  logic [PA_W-1:0]   tbl_base,
    input  logic [LEN_W-1:0]  tbl_span,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault
);

    vaddr_t    va;
    seg_desc_t wdesc;
    seg_desc_t desc;
    verdict_e  verdict;
    logic [PA_W-1:0] paddr_c;
    seg_rsp_t  rsp_q;

    assign va    = vaddr_t'(req_vaddr);
    assign wdesc = '{live: tbl_live, base: tbl_base, span: tbl_span};

    seg_table u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_we),
        .wr_idx  (tbl_sel),
        .wr_desc (wdesc),
        .rd_idx  (va.sel),
        .rd_desc (desc)
    );

    seg_check u_check (
        .desc    (desc),
        .off     (va.off),
        .verdict (verdict),
        .paddr   (paddr_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= req_valid;
            if (req_valid) begin
                rsp_q.fault <= (verdict != XL_OK);
                rsp_q.paddr <= paddr_c;
            end
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_fault = rsp_q.fault;

    p_resp_timing_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid)
        else $error("missing response");

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)))
        else $error("idle response changed");

    p_fault_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0))
        else $error("faulting response has address");

    p_ok_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_fault || ($past(desc.live) &&
                        ({1'b0, $past(va.off)} < $past(desc.span)))))
        else $error("accepted access outside segment");

endmodule

// File: tb/tb_seg_translator.sv
module tb_seg_translator;

    logic        clk = 1'b0;
    logic        rst;
    logic        tbl_we;
    logic [7:0]  tbl_sel;
    logic        tbl_live;
    logic [31:0] tbl_base;
    logic [24:0] tbl_span;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;

    int checks = 0;
    int failures = 0;

    logic        m_live [256];
    logic [31:0] m_base [256];
    logic [24:0] m_span [256];
    logic        e_valid;
    logic [31:0] e_paddr;
    logic        e_fault;

    always #2.5 clk = ~clk;

    seg_translator dut (
        .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
        .tbl_live(tbl_live), .tbl_base(tbl_base), .tbl_span(tbl_span),
        .req_valid(req_valid), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    function automatic logic exp_fault(input logic [31:0] va);
        return !m_live[va[31:24]] || ({1'b0, va[23:0]} >= m_span[va[31:24]]);
    endfunction

    function automatic logic [31:0] exp_paddr(input logic [31:0] va);
        return exp_fault(va) ? 32'h0 : m_base[va[31:24]] + {8'h0, va[23:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive after a falling edge, check at the next falling edge.
    task automatic cycle(input string tag, input logic we, input logic [7:0] sel,
                         input logic live, input logic [31:0] base, input logic [24:0] span,
                         input logic rv, input logic [31:0] va);
        tbl_we = we; tbl_sel = sel; tbl_live = live; tbl_base = base; tbl_span = span;
        req_valid = rv; req_vaddr = va;
        e_valid = rv;
        if (rv) begin
            e_fault = exp_fault(va);
            e_paddr = exp_paddr(va);
        end
        @(posedge clk);
        @(negedge clk);
        if (we) begin
            m_live[sel] = live; m_base[sel] = base; m_span[sel] = span;
        end
        check({tag, " R3 valid"}, {31'h0, rsp_valid}, {31'h0, e_valid});
        check({tag, " R4 fault"}, {31'h0, rsp_fault}, {31'h0, e_fault});
        check({tag, " R3 paddr"}, rsp_paddr, e_paddr);
    endtask

    task automatic wr(input logic [7:0] sel, input logic live, input logic [31:0] base,
                      input logic [24:0] span);
        cycle("wr", 1'b1, sel, live, base, span, 1'b0, 32'h0);
    endtask

    task automatic rd(input string tag, input logic [31:0] va);
        cycle(tag, 1'b0, 8'h0, 1'b0, 32'h0, 25'h0, 1'b1, va);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EC7A11));
        for (int i = 0; i < 256; i++) begin
            m_live[i] = 1'b0; m_base[i] = '0; m_span[i] = '0;
        end
        e_valid = 1'b0; e_paddr = '0; e_fault = 1'b0;
        tbl_we = 0; tbl_sel = 0; tbl_live = 0; tbl_base = 0; tbl_span = 0;
        req_valid = 0; req_vaddr = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset valid", {31'h0, rsp_valid}, 32'h0);
        check("R1 reset paddr", rsp_paddr, 32'h0);
        check("R1 reset fault", {31'h0, rsp_fault}, 32'h0);
        rd("R1 absent after reset", 32'h0500_0010);
        check("R1 R5 fault after reset", {31'h0, rsp_fault}, 32'h1);

        // R2 R3: field split and sum
        wr(8'h03, 1'b1, 32'h0002_0000, 25'h1000);
        rd("R2 seg3 hit", 32'h0300_0abc);
        check("R2 R3 seg3 addr", rsp_paddr, 32'h0002_0abc);
        // R4 boundary
        rd("R4 off=len-1", 32'h0300_0fff);
        rd("R4 off=len", 32'h0300_1000);
        check("R4 off=len faults", {31'h0, rsp_fault}, 32'h1);
        check("R6 fault addr zero", rsp_paddr, 32'h0);
        wr(8'h04, 1'b1, 32'h1000_0000, 25'h0);
        rd("R4 zero length", 32'h0400_0000);
        wr(8'hff, 1'b1, 32'h0000_8000, 25'h100_0000);
        rd("R4 full length", 32'hff_ffffff);
        check("R4 full len ok", {31'h0, rsp_fault}, 32'h0);
        // R5 absent with big span
        wr(8'h06, 1'b0, 32'h1234_0000, 25'h100_0000);
        rd("R5 absent", 32'h0600_0001);
        // R10 wrap
        wr(8'h07, 1'b1, 32'hFFFF_FF00, 25'h100_0000);
        rd("R10 wrap", 32'h0700_0200);
        check("R10 wrapped addr", rsp_paddr, 32'h0000_0100);
        // R7 hold
        cycle("R7 idle", 1'b0, 8'h0, 1'b0, 32'h0, 25'h0, 1'b0, 32'hFF00_0000);
        check("R7 hold addr", rsp_paddr, 32'h0000_0100);
        // R8 same-cycle write and lookup: old contents
        cycle("R8 same cycle", 1'b1, 8'h03, 1'b1, 32'h4000_0000, 25'h10, 1'b1, 32'h0300_0020);
        check("R8 old contents", rsp_paddr, 32'h0002_0020);
        rd("R8 new contents", 32'h0300_0020);
        check("R8 new span faults", {31'h0, rsp_fault}, 32'h1);
        rd("R8 new base", 32'h0300_0004);
        check("R8 new base addr", rsp_paddr, 32'h4000_0004);
        // R9 invalidate
        wr(8'h03, 1'b0, 32'h4000_0000, 25'h10);
        rd("R9 invalidated", 32'h0300_0004);

        // Random traffic over a few descriptors
        for (int n = 0; n < 3000; n++) begin
            logic [7:0]  s;
            logic [23:0] o;
            logic [24:0] sp;
            logic [31:0] r;
            r  = $urandom;
            s  = (r[3:0] == 4'hf) ? 8'hff : {5'h0, r[6:4]};
            sp = (r[9:8] == 2'd0) ? 25'h100_0000 : {17'h0, r[23:16]};
            o  = r[10] ? {16'h0, r[31:24]} : 24'($urandom);
            cycle("R3 R4 random", r[11] & r[12], s, r[13] | r[14], $urandom, sp,
                  r[15] | r[7], {s, o});
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule